// File: doc/BRIEF.md
# SDRAM Byte-Lane Masked Data Path

This block is the 16-bit data side of an SDRAM-style memory interface. It holds a small column store and moves bursts of words in and out of it. Each 16-bit word is split into two byte lanes, and each lane has its own mask input. A write or read strobe starts a fixed-length burst at a given column. The column then steps by one on every following beat.

The two directions use the mask at different times. On a write beat, the mask is applied in the same cycle as the data: a lane with its mask low is stored, and a lane with its mask high keeps its old contents. On a read beat, the mask sampled with that beat decides the lane's output enable two clocks later, which is also when the beat's data appears. The outputs are plain signals, a data word and one enable bit per lane, so the block stays synthesizable. A wrapper around it can build the tri-state pins.

Top module: `sdram_bytemask_dp`

## Requirements
- R1: Mask bit `mask_lo` governs lane 0 (data bits 7:0, enable `oe_lo`), and `mask_hi` governs lane 1 (data bits 15:8, enable `oe_hi`).
- R2: On a write beat, every lane whose mask is low stores that cycle's `wdata` byte at the beat's column.
- R3: On a write beat, a lane whose mask is high keeps its stored byte unchanged.
- R4: A read beat sampled at rising edge k drives the stored word of its column on `rdata` from edge k+2 until edge k+3, on lanes whose mask was low at edge k. Those lanes have their enable high in that window.
- R5: A lane whose mask was high at read beat edge k has its enable low from edge k+2, and its `rdata` byte reads zero.
- R6: A strobe starts a burst of BURST_LEN beats (default 4). The first beat is in the strobe cycle at `col_in`. Each following beat uses the previous column plus one, wrapping from 255 to 0.
- R7: A read beat with both masks high still uses up its beat and advances the burst column.
- R8: A strobe arriving during a burst abandons the remaining beats and starts a new burst at the new column and direction.
- R9: When `wr_cmd` and `rd_cmd` are high together, the burst is a write.
- R10: After reset, and in any output cycle with no read beat two edges earlier, both enables are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | Start a write burst |
| rd_cmd | input | 1 | Start a read burst |
| col_in | input | 8 | Starting column of the burst |
| wdata | input | 16 | Write data for the current beat |
| mask_lo | input | 1 | Lane 0 mask; high blocks the lane |
| mask_hi | input | 1 | Lane 1 mask; high blocks the lane |
| rdata | output | 16 | Read data, with disabled lanes zeroed |
| oe_lo | output | 1 | Lane 0 output enable |
| oe_hi | output | 1 | Lane 1 output enable |

## Verification
Every column is first written unmasked and then rewritten with each of the four mask codes in turn. The whole store is then read back with the mask codes rotated against the column. This pairing separates a swapped lane, a write that ignores its mask, and a read enable taken one clock early or late. Dedicated bursts cover the column wrap from 255 to 0, a strobe cutting a burst short, a fully masked read beat that must still advance the column, and both strobes arriving in the same cycle. Idle stretches show that the enables drop when no read is in flight.

// File: rtl/sdbm_pkg.sv
package sdbm_pkg;
    localparam int LANES    = 2;
    localparam int LANE_W   = 8;
    localparam int WORD_W   = LANES * LANE_W;
    // read data and enables appear this many edges after the beat edge
    localparam int RD_LAT   = 2;

    typedef struct packed {
        logic [LANES-1:0]  oe;
        logic [WORD_W-1:0] data;
    } rd_stage_t;
endpackage

// File: rtl/sdbm_burst_ctrl.sv
module sdbm_burst_ctrl #(
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             rd_cmd,
    input  logic [COL_W-1:0] col_in,
    output logic             beat_v,
    output logic             beat_wr,
    output logic [COL_W-1:0] beat_col
);
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    typedef struct packed {
        logic             active;
        logic             is_wr;
        logic [COL_W-1:0] col;
        logic [CNT_W-1:0] left;
    } burst_t;

    burst_t s_d, s_q;
    logic   cmd;

    always_comb begin
        cmd      = wr_cmd | rd_cmd;
        // a strobe always wins over a running burst; write wins over read
        beat_v   = cmd | s_q.active;
        beat_wr  = cmd ? wr_cmd : s_q.is_wr;
        beat_col = cmd ? col_in : s_q.col;

        s_d = s_q;
        if (cmd) begin
            s_d.is_wr  = wr_cmd;
            s_d.col    = col_in + 1'b1;
            s_d.left   = CNT_W'(BURST_LEN - 1);
            s_d.active = (BURST_LEN > 1);
        end else if (s_q.active) begin
            s_d.col    = s_q.col + 1'b1;
            s_d.left   = s_q.left - 1'b1;
            s_d.active = (s_q.left != CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !(wr_cmd || rd_cmd)) |->
            (beat_col == COL_W'($past(beat_col) + 1'b1)));

    // R6
    live_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.left != '0 && s_q.left < CNT_W'(BURST_LEN)));

    // R9
    wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && rd_cmd) |-> (beat_v && beat_wr));
endmodule

// File: rtl/sdbm_lane_store.sv
module sdbm_lane_store #(
    parameter int COL_W  = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [COL_W-1:0]  addr,
    input  logic [LANE_W-1:0] wbyte,
    output logic [LANE_W-1:0] rbyte
);
    localparam int DEPTH = 1 << COL_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wbyte;
        end
    end

    always_comb begin
        rbyte = mem[addr];
    end

    // R2
    lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(addr)] == $past(wbyte)));

    // R3
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (mem[$past(addr)] == $past(rbyte)));
endmodule

// File: rtl/sdbm_rd_pipe.sv
module sdbm_rd_pipe
    import sdbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_rd,
    input  logic [LANES-1:0]  mask,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  oe
);
    typedef struct packed {
        rd_stage_t [RD_LAT:0] stg;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        p_d.stg[0].oe   = {LANES{beat_rd}} & ~mask;
        p_d.stg[0].data = word_in;
        for (int i = 1; i <= RD_LAT; i++) begin
            p_d.stg[i] = p_q.stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign oe = p_q.stg[RD_LAT].oe;

    for (genvar g = 0; g < LANES; g++) begin : g_gate
        assign rdata[g*LANE_W +: LANE_W] =
            p_q.stg[RD_LAT].oe[g] ? p_q.stg[RD_LAT].data[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sdram_bytemask_dp.sv
module sdram_bytemask_dp
    import sdbm_pkg::*;
#(
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             rd_cmd,
    input  logic [COL_W-1:0] col_in,
    input  logic [15:0]      wdata,
    input  logic             mask_lo,
    input  logic             mask_hi,
    output logic [15:0]      rdata,
    output logic             oe_lo,
    output logic             oe_hi
);
    logic              beat_v, beat_wr, beat_rd;
    logic [COL_W-1:0]  beat_col;
    logic [LANES-1:0]  mask;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] rd_word;
    logic [LANES-1:0]  oe;

    assign mask    = {mask_hi, mask_lo};
    assign beat_rd = beat_v & ~beat_wr;

    sdbm_burst_ctrl #(
        .COL_W     (COL_W),
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cmd   (wr_cmd),
        .rd_cmd   (rd_cmd),
        .col_in   (col_in),
        .beat_v   (beat_v),
        .beat_wr  (beat_wr),
        .beat_col (beat_col)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = beat_v & beat_wr & ~mask[g];

        sdbm_lane_store #(
            .COL_W  (COL_W),
            .LANE_W (LANE_W)
        ) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lane_we[g]),
            .addr  (beat_col),
            .wbyte (wdata[g*LANE_W +: LANE_W]),
            .rbyte (rd_word[g*LANE_W +: LANE_W])
        );
    end

    sdbm_rd_pipe u_rd_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_rd (beat_rd),
        .mask    (mask),
        .word_in (rd_word),
        .rdata   (rdata),
        .oe      (oe)
    );

    assign oe_lo = oe[0];
    assign oe_hi = oe[1];

    // R4 R1
    lo_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_lo |-> $past(beat_rd && !mask_lo, 3));

    // R5 R10
    lo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && !$past(beat_rd && !mask_lo, 3)) |-> !oe_lo);

    // R4 R1
    hi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_hi |-> $past(beat_rd && !mask_hi, 3));

    // R5
    zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_lo |-> rdata[7:0] == 8'h00) and (!oe_hi |-> rdata[15:8] == 8'h00));
endmodule

// File: tb/sdram_bytemask_dp_bench.sv
module sdram_bytemask_dp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_cmd = 1'b0, rd_cmd = 1'b0;
    logic [7:0]  col_in = '0;
    logic [15:0] wdata = '0;
    logic        mask_lo = 1'b0, mask_hi = 1'b0;
    logic [15:0] rdata;
    logic        oe_lo, oe_hi;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sdram_bytemask_dp u_sdram_bytemask_dp (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .rd_cmd(rd_cmd),
        .col_in(col_in), .wdata(wdata), .mask_lo(mask_lo), .mask_hi(mask_hi),
        .rdata(rdata), .oe_lo(oe_lo), .oe_hi(oe_hi)
    );

    // bench-side view of the store and of the burst sequencing
    logic [15:0] mm [256];
    bit          m_wr;
    logic [7:0]  m_col;
    int          m_left = 0;
    logic [17:0] exp_q [4];
    string       exp_tag [4];
    int          cyc = 0;

    function automatic logic [15:0] pat(input logic [7:0] c, input logic [7:0] salt);
        return {c ^ salt, c + salt};
    endfunction

    task automatic check(input string tag, input logic [17:0] got, input logic [17:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got oe=%b data=%h expected oe=%b data=%h",
                     tag, got[17:16], got[15:0], want[17:16], want[15:0]);
        end
    endtask

    // one clock: check the output due now, model the beat, drive inputs
    task automatic step(input bit wr, input bit rd, input logic [7:0] c,
                        input logic [15:0] wd, input logic [1:0] m, input string tag);
        bit         bv, bw;
        logic [7:0] bc;
        int         s;
        @(negedge clk);
        s = cyc % 4;
        check(exp_tag[s], {oe_hi, oe_lo, rdata}, exp_q[s]);
        bv = 1'b0; bw = 1'b0; bc = '0;
        if (wr || rd) begin
            bv = 1'b1; bw = wr; bc = c;
            m_wr = wr; m_col = c + 8'd1; m_left = 3;
        end else if (m_left > 0) begin
            bv = 1'b1; bw = m_wr; bc = m_col;
            m_col = m_col + 8'd1; m_left--;
        end
        s = (cyc + 3) % 4;
        exp_q[s]   = '0;
        exp_tag[s] = tag;
        if (bv && !bw) begin
            exp_q[s][17:16] = ~m;
            exp_q[s][7:0]   = m[0] ? 8'h00 : mm[bc][7:0];
            exp_q[s][15:8]  = m[1] ? 8'h00 : mm[bc][15:8];
        end
        if (bv && bw) begin
            if (!m[0]) mm[bc][7:0]  = wd[7:0];
            if (!m[1]) mm[bc][15:8] = wd[15:8];
        end
        wr_cmd = wr; rd_cmd = rd; col_in = c; wdata = wd;
        mask_lo = m[0]; mask_hi = m[1];
        cyc++;
    endtask

    task automatic burst(input bit wr, input bit rd, input logic [7:0] c,
                         input logic [7:0] salt, input int mrot, input string tag);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] cc;
            cc = c + 8'(k);
            step((k == 0) && wr, (k == 0) && rd, (k == 0) ? c : 8'h00,
                 pat(cc, salt), 2'((k + mrot) % 4), tag);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            exp_q[i] = '0;
            exp_tag[i] = "R10 reset";
        end
        repeat (3) @(posedge clk);
        // R10: reset state at the ports
        @(negedge clk);
        check("R10 reset", {oe_hi, oe_lo, rdata}, 18'h0);
        rst_n = 1'b1;
        repeat (4) step(0, 0, 8'h00, 16'h0, 2'b00, "R10 idle after reset");

        // fill every column unmasked (R2)
        for (int b = 0; b < 64; b++) burst(1, 0, 8'(b * 4), 8'h3c, 0, "R2 R6");
        // rewrite with all mask codes, beat k uses mask k (R1 R2 R3)
        for (int b = 0; b < 64; b++) burst(1, 0, 8'(b * 4), 8'hc5, 0, "R1 R2 R3");
        // read back everything with rotated masks (R1 R4 R5 R7)
        for (int b = 0; b < 64; b++) burst(0, 1, 8'(b * 4), 8'h00, b % 4, "R1 R4 R5 R7");
        repeat (4) step(0, 0, 8'h00, 16'h0, 2'b00, "R10 idle");

        // column wrap 255 -> 0 on write and read (R6)
        burst(1, 0, 8'hfe, 8'h77, 1, "R6 wrap");
        burst(0, 1, 8'hfe, 8'h00, 0, "R6 wrap");
        burst(0, 1, 8'hfd, 8'h00, 3, "R6 R7 wrap");

        // fully masked beats still step the column (R7)
        step(0, 1, 8'h40, 16'h0, 2'b11, "R7");
        step(0, 0, 8'h00, 16'h0, 2'b11, "R7");
        step(0, 0, 8'h00, 16'h0, 2'b00, "R7");
        step(0, 0, 8'h00, 16'h0, 2'b00, "R7");

        // interrupt a read burst, then a write burst (R8)
        step(0, 1, 8'h10, 16'h0, 2'b00, "R8");
        step(0, 0, 8'h00, 16'h0, 2'b00, "R8");
        step(0, 1, 8'h80, 16'h0, 2'b10, "R8");
        step(0, 0, 8'h00, 16'h0, 2'b00, "R8");
        step(1, 0, 8'h22, 16'hbeef, 2'b00, "R8");
        step(0, 0, 8'h00, 16'h1234, 2'b00, "R8");
        step(0, 1, 8'h21, 16'h0, 2'b00, "R8");
        repeat (4) step(0, 0, 8'h00, 16'h0, 2'b00, "R8");

        // both strobes together make a write (R9)
        step(1, 1, 8'h30, 16'ha55a, 2'b00, "R9");
        repeat (3) step(0, 0, 8'h00, 16'h0f0f, 2'b01, "R9");
        burst(0, 1, 8'h30, 8'h00, 0, "R9");
        repeat (6) step(0, 0, 8'h00, 16'h0, 2'b00, "R10 idle");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule